// File: doc/BRIEF.md
# Cascadable presettable binary counter

A synchronous up-counter, four bits wide by default, that can be preset from a parallel data word. It is used on its own as a programmable divider, or as one slice of a wider counter. Counting needs two enables. A parallel enable, `en_par`, is shared by every slice. A trickle enable, `en_trk`, is fed from the carry of the slice below. The carry output is combinational. It is high only when the trickle enable is high and the slice sits at its top value. Because of this, a chain of slices advances in a single clock, with no ripple between stages.

The four modes have a fixed priority, highest first: clear, load, count, hold. The parameter `ASYNC_CLR` chooses how clear behaves. With `ASYNC_CLR=1` (the default), the counter clears at once, without waiting for the clock. With `ASYNC_CLR=0`, it clears on the next rising edge. Apart from an asynchronous clear, the count changes only on the rising clock edge.

Top module: `casc_counter`

## Requirements
- R1: The count wraps from all ones (15 for WIDTH=4) to zero when it is counted.
- R2: When `clr_n`=1, `load_n`=1, `en_par`=1 and `en_trk`=1, each rising edge adds one to `count`.
- R3: When clear and load are inactive and either `en_par` or `en_trk` is 0, `count` is unchanged by a rising edge.
- R4: When `clr_n`=1 and `load_n`=0, the next rising edge copies `din` into `count`, whatever the values of the count enables.
- R5: When `ASYNC_CLR=0`, `clr_n`=0 sets `count` to zero on the next rising edge. This applies even if `load_n`=0 or both enables are 1, and the count does not change before that edge.
- R6: When `ASYNC_CLR=1`, `clr_n`=0 sets `count` to zero at once, without a clock edge, and holds it there while `clr_n` stays low.
- R7: `carry` is 1 exactly when `en_trk`=1 and `count` is all ones. Neither `en_par` nor `load_n` affects it.
- R8: `carry` is combinational. It rises as soon as a load of all ones completes with `en_trk`=1. It falls as soon as `en_trk` falls, with no clock edge in between.
- R9: Two slices chained (carry of the lower slice into `en_trk` of the upper slice, and a common enable on both `en_par` inputs and on the lower `en_trk`) count from 0 to 255 and wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Clear, active low; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_n | input | 1 | Parallel load enable, active low |
| din | input | WIDTH | Parallel preset data |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `carry` |
| count | output | WIDTH | Registered count value |
| carry | output | 1 | Terminal count, combinational |

## Verification
Clear, load and count can all be requested in the same cycle. The bench drives `clr_n` low while `load_n` is low and both enables are high. It then expects zero in both variants, and never the loaded or incremented value. In the same way, load is requested with both enables high, and the bench expects exactly `din`, not `din`+1. The asynchronous and synchronous variants are fed identical inputs. A clear dropped in the middle of a cycle must zero the asynchronous instance at once while the synchronous instance still shows its old value until the next edge.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } ctr_mode_e;

endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
  import casc_counter_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output ctr_mode_e mode
);

  // Fixed priority: clear, load, count, hold
  always_comb begin
    if (!clr_n)                mode = MODE_CLEAR;
    else if (!load_n)          mode = MODE_LOAD;
    else if (en_par && en_trk) mode = MODE_COUNT;
    else                       mode = MODE_HOLD;
  end

endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
  import casc_counter_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  ctr_mode_e        mode,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] q_next;

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_next = ZERO;
      MODE_LOAD:  q_next = din;
      MODE_COUNT: q_next = q + ONE;
      default:    q_next = q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= ZERO;
        else        q <= q_next;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= q_next;
      end
    end
  endgenerate

  assert_count_inc_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_COUNT) |=> (q == $past(q) + ONE));

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_COUNT && q == '1) |=> (q == ZERO));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_HOLD) |=> $stable(q));

  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_LOAD) |=> (q == $past(din)));

  generate
    if (!ASYNC_CLR) begin : g_sync_chk
      assert_sync_clear_R5: assert property (@(posedge clk)
        (!clr_n) |=> (q == ZERO));
    end
  endgenerate

endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             carry
);

  always_comb carry = en_trk & (&q);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] count,
  output logic             carry
);

  ctr_mode_e mode;

  ctr_mode_dec u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  ctr_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .mode  (mode),
    .din   (din),
    .q     (count)
  );

  ctr_tc #(.WIDTH(WIDTH)) u_tc (
    .q      (count),
    .en_trk (en_trk),
    .carry  (carry)
  );

  assert_carry_needs_trk_R7: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> en_trk);

  assert_carry_top_R7: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (count == '1));

endmodule

// File: tb/casc_counter_test.sv
module casc_counter_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt_a, cnt_s;
  logic       cy_a, cy_s;

  logic       c_clr_n = 1'b0, c_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_cy, hi_cy;

  int total = 0;
  int fails = 0;

  casc_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .count(cnt_a), .carry(cy_a));

  casc_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) uut_s (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .count(cnt_s), .carry(cy_s));

  casc_counter #(.WIDTH(4)) st_lo (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_en), .en_trk(c_en), .count(lo_q), .carry(lo_cy));

  casc_counter #(.WIDTH(4)) st_hi (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_en), .en_trk(lo_cy), .count(hi_q), .carry(hi_cy));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1; din = 4'd0;
    step();
    chk("R6 reset async", cnt_a, 0);
    chk("R5 reset sync", cnt_s, 0);
    chk("R7 carry at reset", cy_a, 0);
    clr_n = 1'b1;
  endtask

  task automatic t_count();
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R2 count async", cnt_a, i);
      chk("R2 count sync", cnt_s, i);
    end
  endtask

  task automatic t_hold();
    en_par = 1'b0; en_trk = 1'b1;
    step(); step();
    chk("R3 hold en_par low", cnt_a, 5);
    en_par = 1'b1; en_trk = 1'b0;
    step();
    chk("R3 hold en_trk low", cnt_a, 5);
    chk("R3 hold sync", cnt_s, 5);
    en_trk = 1'b1;
  endtask

  task automatic t_load();
    load_n = 1'b0; din = 4'd9; en_par = 1'b0; en_trk = 1'b0;
    step();
    chk("R4 load enables low", cnt_a, 9);
    din = 4'd3; en_par = 1'b1; en_trk = 1'b1;
    step();
    chk("R4 load over count", cnt_a, 3);
    chk("R4 load over count sync", cnt_s, 3);
    load_n = 1'b1;
  endtask

  task automatic t_wrap();
    load_n = 1'b0; din = 4'd14;
    step();
    load_n = 1'b1;
    step();
    chk("R1 reach 15", cnt_a, 15);
    chk("R7 carry at 15", cy_a, 1);
    step();
    chk("R1 wrap to 0", cnt_a, 0);
    chk("R1 wrap sync", cnt_s, 0);
    chk("R7 carry after wrap", cy_a, 0);
  endtask

  task automatic t_carry();
    load_n = 1'b0; din = 4'd15; en_par = 1'b0; en_trk = 1'b1;
    step();
    chk("R8 carry after load 15", cy_a, 1);
    en_trk = 1'b0;
    #1;
    chk("R8 carry falls with en_trk", cy_a, 0);
    en_trk = 1'b1;
    #1;
    chk("R8 carry rises with en_trk", cy_a, 1);
    en_par = 1'b1;
    #1;
    chk("R7 en_par no effect", cy_a, 1);
    load_n = 1'b1;
    #1;
    chk("R7 load_n no effect", cy_a, 1);
    en_par = 1'b0;
    #1;
    chk("R7 en_par low no effect", cy_a, 1);
    step();
    chk("R3 hold at 15", cnt_a, 15);
  endtask

  task automatic t_sync_clr();
    load_n = 1'b0; din = 4'd6; en_par = 1'b1; en_trk = 1'b1;
    step();
    clr_n = 1'b0; din = 4'd10;
    #1;
    chk("R5 no change before edge", cnt_s, 6);
    step();
    chk("R5 clear beats load and count", cnt_s, 0);
    chk("R6 clear beats load async", cnt_a, 0);
    step();
    chk("R6 stays zero while low", cnt_a, 0);
    clr_n = 1'b1; load_n = 1'b1;
  endtask

  task automatic t_async_clr();
    load_n = 1'b0; din = 4'd5; en_par = 1'b0;
    step();
    load_n = 1'b1;
    #2;
    clr_n = 1'b0;
    #1;
    chk("R6 immediate clear", cnt_a, 0);
    chk("R5 sync waits for edge", cnt_s, 5);
    step();
    chk("R5 sync cleared at edge", cnt_s, 0);
    clr_n = 1'b1;
  endtask

  task automatic t_cascade();
    c_clr_n = 1'b0; c_en = 1'b0;
    step();
    c_clr_n = 1'b1;
    chk("R9 chain reset", {hi_q, lo_q}, 0);
    c_en = 1'b1;
    for (int i = 1; i <= 260; i++) begin
      step();
      chk("R9 chain count", {hi_q, lo_q}, i % 256);
    end
    c_en = 1'b0;
    step();
    chk("R9 chain hold", {hi_q, lo_q}, 260 % 256);
  endtask

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_count();
    t_hold();
    t_load();
    t_wrap();
    t_carry();
    t_sync_clr();
    t_async_clr();
    t_cascade();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule